// File: doc/BRIEF.md
# Single-Byte Opcode Toy Processor

This block is a very small processor that runs programs kept in a byte-wide synchronous RAM inside the block. The program counter is 16 bits wide and starts at zero. The only general register is an 8-bit accumulator called R0. Every instruction is one byte. Any jump target, immediate value or store address is fixed by the opcode itself, so no operand is ever fetched. Each instruction takes two clock cycles: a fetch cycle that reads the byte at the PC, then an execute cycle that updates the PC, R0 and, for the store opcode, the memory.

Programs enter through a byte-wide load port that follows valid/ready rules. A beat transfers on a rising edge where both `ld_valid` and `ld_ready` are high. `ld_ready` is high only while `run` is low, so a host can fill the memory only while the core is stopped. While `run` is high the port gives back-pressure and any offered beat waits or is dropped by the host. The same address input also drives a read path, so the host can read memory back one cycle later. The halt flag, the PC and R0 are visible for observation.

The RAM holds 2^MEM_AW bytes and decodes only the low MEM_AW bits of each 16-bit address. The default is 4096 bytes, which covers every fixed address the opcodes use.

Top module: `tp_cpu`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, the block sets PC to 0x0000, R0 to 0x00 and `halted` to 0, so the first byte executed comes from address 0x0000.
- R2: Each instruction takes exactly two rising edges with `run` high: one to fetch, one to execute. With a stop opcode at address N and no jump before it, `halted` rises on rising edge 2N+2 after `run` is raised.
- R3: Opcodes that are not jumps and not the stop opcode advance the PC by exactly one.
- R4: Opcode 0x2B loads the PC with 0x0AD0. Opcode 0x24 loads the PC with 0x0BC8. Neither changes R0.
- R5: Opcode 0x15 sets R0 to 3. Opcode 0x2E adds 2 to R0. Opcode 0x25 adds 1 to R0. Both additions wrap modulo 256.
- R6: Opcode 0xC0 writes the current R0 to address 0x0F00 in its execute cycle and then clears R0 to 0.
- R7: Opcode 0xFF-free stop code 0x3F raises `halted`. The PC then stays at the address of the stop opcode, and `halted` stays high until the next reset.
- R8: Every opcode other than 0x2B, 0x24, 0x15, 0x2E, 0x25, 0xC0 and 0x3F leaves R0 and memory unchanged and advances the PC by one.
- R9: `ld_ready` equals the inverse of `run`. A byte `ld_data` is written to `ld_addr` only on an edge where `ld_valid` and `ld_ready` are both high; a beat offered while `run` is high leaves memory unchanged. `ld_rdata` shows the byte at the `ld_addr` sampled on the previous edge.
- R10: While `run` is low the core does not advance: PC, R0, `halted` and its internal phase hold. Raising `run` again resumes execution where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Core executes while high; load port is open while low |
| ld_valid | input | 1 | Load beat offered |
| ld_ready | output | 1 | Load port accepts beats (high when `run` is low) |
| ld_addr | input | 16 | Address for a load write and for readback |
| ld_data | input | 8 | Byte to write |
| ld_rdata | output | 8 | Byte at the previously sampled `ld_addr` |
| halted | output | 1 | Stop opcode executed; held until reset |
| pc | output | 16 | Program counter |
| r0 | output | 8 | Accumulator R0 |

## Verification
All 256 opcode values are swept. Each one sits right after a load-immediate and before a stop, with stops also placed at both jump targets. The resulting PC, R0 and byte at 0x0F00 show which opcodes jump, which change R0, which store, which stop and which fall through as no-ops. Long runs of add-two and increment test wrap-around at 256. A row of no-ops ending in a stop confirms the two-cycle timing. Pausing `run` mid-program, and offering load beats while the core runs, show that the core freezes and that the port pushes back.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  localparam logic [DATA_W-1:0] OP_JMP_LO  = 8'h2B;
  localparam logic [DATA_W-1:0] OP_JMP_HI  = 8'h24;
  localparam logic [DATA_W-1:0] OP_SET3    = 8'h15;
  localparam logic [DATA_W-1:0] OP_ADD2    = 8'h2E;
  localparam logic [DATA_W-1:0] OP_INC     = 8'h25;
  localparam logic [DATA_W-1:0] OP_STORE   = 8'hC0;
  localparam logic [DATA_W-1:0] OP_STOP    = 8'h3F;

  localparam logic [ADDR_W-1:0] TGT_LO     = 16'h0AD0;
  localparam logic [ADDR_W-1:0] TGT_HI     = 16'h0BC8;
  localparam logic [ADDR_W-1:0] STORE_ADDR = 16'h0F00;

  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_HALT} phase_t;
  typedef enum logic [1:0] {ACC_KEEP, ACC_SET, ACC_ADD, ACC_CLR} acc_op_t;

  typedef struct packed {
    logic              jump;
    logic [ADDR_W-1:0] target;
    acc_op_t           acc_op;
    logic [DATA_W-1:0] imm;
    logic              store;
    logic              stop;
  } ctl_t;
endpackage

// File: rtl/tp_mem.sv
module tp_mem #(
  parameter int AW = 16,
  parameter int MEM_AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  input  logic          b_we,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DW-1:0]     ram [DEPTH];
  logic [MEM_AW-1:0] a_idx, b_idx;

  assign a_idx = a_addr[MEM_AW-1:0];
  assign b_idx = b_addr[MEM_AW-1:0];

  always_ff @(posedge clk) begin
    if (b_we)      ram[b_idx] <= b_wdata;
    else if (a_we) ram[a_idx] <= a_wdata;
    a_rdata <= ram[a_idx];
    b_rdata <= ram[b_idx];
  end

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst) !(a_we && b_we)); // R9
endmodule

// File: rtl/tp_decode.sv
module tp_decode
  import tp_pkg::*;
(
  input  logic [DATA_W-1:0] opcode,
  output ctl_t              ctl
);
  always_comb begin
    ctl = '{jump: 1'b0, target: '0, acc_op: ACC_KEEP, imm: '0, store: 1'b0, stop: 1'b0};
    unique case (opcode)
      OP_JMP_LO: begin ctl.jump = 1'b1; ctl.target = TGT_LO; end
      OP_JMP_HI: begin ctl.jump = 1'b1; ctl.target = TGT_HI; end
      OP_SET3:   begin ctl.acc_op = ACC_SET; ctl.imm = 8'd3; end
      OP_ADD2:   begin ctl.acc_op = ACC_ADD; ctl.imm = 8'd2; end
      OP_INC:    begin ctl.acc_op = ACC_ADD; ctl.imm = 8'd1; end
      OP_STORE:  begin ctl.store = 1'b1; ctl.acc_op = ACC_CLR; end
      OP_STOP:   ctl.stop = 1'b1;
      default:   ;
    endcase
  end
endmodule

// File: rtl/tp_core.sv
module tp_core
  import tp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [DATA_W-1:0] instr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              halted,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] r0
);
  phase_t            ph_q;
  logic [ADDR_W-1:0] pc_q, pc_nx;
  logic [DATA_W-1:0] r0_q, r0_nx;
  ctl_t              ctl;
  logic              in_exec;

  tp_decode u_dec (.opcode(instr), .ctl(ctl));

  assign in_exec = run && (ph_q == ST_EXEC);

  always_comb begin
    unique case (ctl.acc_op)
      ACC_SET: r0_nx = ctl.imm;
      ACC_ADD: r0_nx = r0_q + ctl.imm;
      ACC_CLR: r0_nx = '0;
      default: r0_nx = r0_q;
    endcase
    if (ctl.jump)      pc_nx = ctl.target;
    else if (ctl.stop) pc_nx = pc_q;
    else               pc_nx = pc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= ST_FETCH;
      pc_q <= '0;
      r0_q <= '0;
    end else if (run) begin
      unique case (ph_q)
        ST_FETCH: ph_q <= ST_EXEC;
        ST_EXEC: begin
          ph_q <= ctl.stop ? ST_HALT : ST_FETCH;
          pc_q <= pc_nx;
          r0_q <= r0_nx;
        end
        default: ph_q <= ST_HALT;
      endcase
    end
  end

  assign mem_we    = in_exec && ctl.store;
  assign mem_addr  = mem_we ? STORE_ADDR : pc_q;
  assign mem_wdata = r0_q;
  assign halted    = (ph_q == ST_HALT);
  assign pc        = pc_q;
  assign r0        = r0_q;

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst) halted |=> halted); // R7
  AST_HALT_PC_HOLD: assert property (@(posedge clk) disable iff (rst) halted |=> $stable(pc_q)); // R7
  AST_FETCH_THEN_EXEC: assert property (@(posedge clk) disable iff (rst)
    (run && ph_q == ST_FETCH) |=> (ph_q == ST_EXEC)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (in_exec && !ctl.jump && !ctl.stop) |=> (pc_q == $past(pc_q) + 16'd1)); // R3
  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(pc_q) && $stable(r0_q) && $stable(ph_q))); // R10
endmodule

// File: rtl/tp_cpu.sv
module tp_cpu
  import tp_pkg::*;
#(
  parameter int MEM_AW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic [DATA_W-1:0] ld_rdata,
  output logic              halted,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] r0
);
  logic [ADDR_W-1:0] core_addr;
  logic              core_we;
  logic [DATA_W-1:0] core_wdata, core_rdata;
  logic              host_we;

  assign ld_ready = !run;
  assign host_we  = ld_valid && ld_ready;

  tp_mem #(.AW(ADDR_W), .MEM_AW(MEM_AW), .DW(DATA_W)) u_mem (
    .clk(clk), .rst(rst),
    .a_addr(core_addr), .a_we(core_we), .a_wdata(core_wdata), .a_rdata(core_rdata),
    .b_addr(ld_addr), .b_we(host_we), .b_wdata(ld_data), .b_rdata(ld_rdata)
  );

  tp_core u_core (
    .clk(clk), .rst(rst), .run(run), .instr(core_rdata),
    .mem_addr(core_addr), .mem_we(core_we), .mem_wdata(core_wdata),
    .halted(halted), .pc(pc), .r0(r0)
  );

  AST_READY_FOLLOWS_RUN: assert property (@(posedge clk) disable iff (rst)
    run |-> !host_we); // R9
endmodule

// File: tb/sim_tp_cpu.sv
module sim_tp_cpu;
  logic clk = 1'b0;
  logic rst = 1'b1, run = 1'b0, ld_valid = 1'b0;
  logic [15:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic        ld_ready, halted;
  logic [7:0]  ld_rdata, r0;
  logic [15:0] pc;
  int errors = 0, checks = 0, cycles = 0;

  always #2.5 clk = ~clk;

  tp_cpu u0 (.clk(clk), .rst(rst), .run(run), .ld_valid(ld_valid), .ld_ready(ld_ready),
             .ld_addr(ld_addr), .ld_data(ld_data), .ld_rdata(ld_rdata),
             .halted(halted), .pc(pc), .r0(r0));

  always @(posedge clk) cycles++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; run = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic load(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); ld_valid = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk); ld_valid = 1'b0;
  endtask

  task automatic peek(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); ld_addr = a;
    @(negedge clk); d = ld_rdata;
  endtask

  task automatic run_to_halt(output int edges);
    @(negedge clk); run = 1'b1; edges = 0;
    while (!halted && edges < 2000) begin
      @(negedge clk); edges++;
    end
  endtask

  initial begin
    logic [7:0] v;
    int n;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pc", pc, 16'h0000); check("R1 r0", r0, 8'h00); check("R1 halted", halted, 1'b0);
    check("R9 ready while stopped", ld_ready, 1'b1);

    // Sweep of every opcode placed after a set-three and before a stop
    for (int op = 0; op < 256; op++) begin
      logic [15:0] epc; logic [7:0] er0, emem;
      do_reset();
      load(16'h0000, 8'h15); load(16'h0001, op[7:0]); load(16'h0002, 8'h3F);
      load(16'h0AD0, 8'h3F); load(16'h0BC8, 8'h3F); load(16'h0F00, 8'h00);
      epc = 16'h0002; er0 = 8'd3; emem = 8'h00;
      case (op)
        8'h2B: epc = 16'h0AD0;
        8'h24: epc = 16'h0BC8;
        8'h15: er0 = 8'd3;
        8'h2E: er0 = 8'd5;
        8'h25: er0 = 8'd4;
        8'hC0: begin er0 = 8'd0; emem = 8'd3; end
        8'h3F: epc = 16'h0001;
        default: ;
      endcase
      run_to_halt(n);
      @(negedge clk); run = 1'b0;
      // R3 R4 R5 R6 R7 R8
      check($sformatf("R4 R3 R8 pc op=%0h", op), pc, epc);
      check($sformatf("R5 R8 r0 op=%0h", op), r0, er0);
      peek(16'h0F00, v);
      check($sformatf("R6 R8 mem op=%0h", op), v, emem);
    end

    // R2 timing: five no-ops then stop at address 5
    do_reset();
    for (int i = 0; i < 5; i++) load(i[15:0], 8'h00);
    load(16'h0005, 8'h3F);
    run_to_halt(n);
    check("R2 edges to halt", n, 12);
    check("R7 pc at stop", pc, 16'h0005);
    repeat (20) @(negedge clk);
    check("R7 halted sticky", halted, 1'b1);
    check("R7 pc hold", pc, 16'h0005);
    run = 1'b0;
    do_reset();
    check("R1 halted cleared", halted, 1'b0);

    // R5 wrap: 130 add-twos gives 260 mod 256 = 4
    for (int i = 0; i < 130; i++) load(i[15:0], 8'h2E);
    load(16'd130, 8'h3F);
    run_to_halt(n); run = 1'b0;
    check("R5 add2 wrap", r0, 8'd4);

    // R5 increment wrap: 127 add-twos (254), then two increments -> 0
    do_reset();
    for (int i = 0; i < 127; i++) load(i[15:0], 8'h2E);
    load(16'd127, 8'h25); load(16'd128, 8'h25); load(16'd129, 8'h3F);
    run_to_halt(n); run = 1'b0;
    check("R5 inc wrap", r0, 8'd0);

    // R10 freeze mid-program
    do_reset();
    load(16'h0000, 8'h25); load(16'h0001, 8'h25); load(16'h0002, 8'h25); load(16'h0003, 8'h3F);
    @(negedge clk); run = 1'b1;
    repeat (3) @(negedge clk);
    run = 1'b0;
    repeat (10) @(negedge clk);
    check("R10 pc frozen", pc, 16'h0001);
    check("R10 r0 frozen", r0, 8'd1);
    check("R10 not halted", halted, 1'b0);
    run_to_halt(n);
    check("R10 resume r0", r0, 8'd3);
    check("R10 resume pc", pc, 16'h0003);

    // R9 back-pressure: beat offered while running is not taken
    do_reset();
    load(16'h0000, 8'h15); load(16'h0001, 8'hC0); load(16'h0002, 8'h3F);
    run_to_halt(n);
    check("R9 ready low while running", ld_ready, 1'b0);
    @(negedge clk); ld_valid = 1'b1; ld_addr = 16'h0F00; ld_data = 8'hAA;
    @(negedge clk); ld_valid = 1'b0; run = 1'b0;
    peek(16'h0F00, v);
    check("R9 write ignored while running", v, 8'h03);
    check("R6 r0 cleared after store", r0, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=<190000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule